// File: doc/BRIEF.md
# Byte-to-66-bit receive payload gearbox

This block is the receive-side gearbox of a WAN interface sublayer. Upstream framing and pointer logic deliver a byte-wide stream in which every byte is tagged as either overhead or payload, and the first payload byte of each payload envelope is marked with a start pulse. The gearbox drops overhead, ignores everything until the first envelope start after reset, and repacks the surviving payload bytes into a continuous stream of 66-bit words, each announced by a one-cycle valid strobe.

Word edges have no relation to byte, envelope or frame edges. An envelope does not hold a whole number of 66-bit words, so the bits left over at the end of one envelope are completed by the first payload bytes of the next. The envelope start may move by whole bytes from one envelope to the next. A later start pulse does not discard those leftover bits. Once 33 payload bytes (264 bits, four words) have been accepted, the leftover count is back to zero.

Top module: `rx_payload_gearbox`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `word_vld` is 0 and `word_out` is all zero. Reset also discards any held partial word and the envelope lock.
- R2: After reset, payload bytes that arrive before the first byte with `env_start` high are discarded. The byte that carries `env_start` is the first byte accepted.
- R3: A byte with `in_ovh` high is never accepted, whether or not the block is locked.
- R4: Bits are packed MSB first. Bit 7 of the first accepted byte becomes bit 65 of the first word, and each following accepted bit fills the next lower position, continuing into the following word.
- R5: `word_vld` goes high for exactly one cycle. It does so in the cycle after the clock edge that accepts the byte bringing the held bit count to 66 or more. `word_out` holds its value between strobes.
- R6: After 33·k payload bytes have been accepted from an empty state, exactly k words have been produced.
- R7: Bits held when a later `env_start` arrives are kept, and the word they began continues with the new envelope's bytes.
- R8: A cycle with `in_valid` low changes nothing, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_byte | input | 8 | Incoming byte, bit 7 sent first |
| in_valid | input | 1 | `in_byte` and its flags are meaningful this cycle |
| in_ovh | input | 1 | The byte is overhead and is dropped |
| env_start | input | 1 | The byte is the first payload byte of an envelope |
| word_out | output | 66 | Recovered word, bit 65 oldest |
| word_vld | output | 1 | One-cycle strobe for a new `word_out` |

## Verification
The bench sends valid non-overhead bytes before any envelope start and checks that none of them reaches a word. A design that locked on the first payload byte would shift every later word. Overhead and idle cycles are scattered through the stream at random, and envelope starts are placed at irregular offsets so that they cut through words. A design that flushed or re-aligned at each start would lose bits at every envelope boundary. The timing of the strobe is checked on every cycle against the byte that completes each word, which catches a wrong bit count as well as a late or doubled strobe. A reset in the middle of a word must leave no bits behind to corrupt the next stream.

// File: rtl/rx_payload_gearbox.sv
module rx_payload_gearbox #(
  parameter int WORD_W = 66,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_valid,
  input  logic              in_ovh,
  input  logic              env_start,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld
);
  localparam int ACC_W = WORD_W + BYTE_W - 1;
  localparam int CAT_W = ACC_W + BYTE_W;
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic             locked;

  wire             take    = in_valid && !in_ovh && (locked || env_start);
  wire [CNT_W-1:0] fill    = cnt + CNT_W'(BYTE_W);
  wire             full    = fill >= CNT_W'(WORD_W);
  wire [CNT_W-1:0] rem     = full ? fill - CNT_W'(WORD_W) : fill;
  wire [CAT_W-1:0] cat     = {acc, in_byte};
  wire [CAT_W-1:0] aligned = cat >> rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      cnt      <= '0;
      locked   <= 1'b0;
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= take && full;
      if (take) begin
        locked <= 1'b1;
        cnt    <= rem;
        acc    <= cat[ACC_W-1:0];
        if (full) word_out <= aligned[WORD_W-1:0];
      end
    end
  end
endmodule

module rx_payload_gearbox_sva (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ovh,
  input logic [65:0] word_out,
  input logic        word_vld
);
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!word_vld && word_out == '0));
  p_vld_needs_payload_r3: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(in_valid && !in_ovh));
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld);
  p_hold_word_r5: assert property (@(posedge clk) disable iff (rst)
    !word_vld |-> $stable(word_out));
endmodule

bind rx_payload_gearbox rx_payload_gearbox_sva u_sva (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ovh(in_ovh),
  .word_out(word_out), .word_vld(word_vld));

// File: tb/sim_rx_payload_gearbox.sv
`timescale 1ns/1ps
module sim_rx_payload_gearbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_byte = '0;
  logic        in_valid = 1'b0;
  logic        in_ovh = 1'b0;
  logic        env_start = 1'b0;
  logic [65:0] word_out;
  logic        word_vld;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [65:0] exp_q[$];
  logic [7:0]  byte_q[$];
  bit          lk_m = 0;
  int          cnt_m = 0;
  int          words_seen = 0;

  always #2.5 clk = ~clk;

  rx_payload_gearbox u0 (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
    .in_ovh(in_ovh), .env_start(env_start), .word_out(word_out), .word_vld(word_vld));

  task automatic chk(input bit ok, input string req, input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle; compute expectation from the requirements and check one cycle later.
  task automatic cyc(input logic [7:0] d, input bit v, input bit o, input bit s, input string req);
    bit acc_b;
    bit done = 0;
    logic [65:0] e = '0;
    in_byte = d; in_valid = v; in_ovh = o; env_start = s;
    acc_b = v && !o && (lk_m || s);
    if (acc_b) begin
      lk_m = 1;
      cnt_m += 8;
      if (cnt_m >= 66) begin
        cnt_m -= 66;
        done = 1;
        e = exp_q.pop_front();
      end
    end
    @(negedge clk);
    chk(word_vld == done, "R5", {65'b0, word_vld}, {65'b0, done});
    if (done) begin
      words_seen++;
      chk(word_out == e, req, word_out, e);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 0; in_ovh = 0; env_start = 0;
    @(negedge clk); @(negedge clk);
    chk(word_vld == 0 && word_out == '0, "R1", word_out, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(word_vld == 0 && word_out == '0, "R1", word_out, '0);
    lk_m = 0; cnt_m = 0; exp_q.delete();
  endtask

  task automatic build(input int nw, input bit directed);
    logic [65:0] w;
    int nb;
    byte_q.delete();
    for (int i = 0; i < nw; i++) begin
      if (directed) w = (i == 0) ? 66'h2_0000_0000_0000_0001 : {2'b01, 32'hA5A5_0F0F, i[31:0]};
      else w = {$urandom(), $urandom(), $urandom()};
      exp_q.push_back(w);
    end
    nb = nw * 66 / 8;
    for (int j = 0; j < nb; j++) begin
      logic [7:0] b = '0;
      for (int k = 0; k < 8; k++) begin
        int p = j * 8 + k;
        b[7-k] = exp_q[exp_q.size() - nw + p / 66][65 - p % 66];
      end
      byte_q.push_back(b);
    end
  endtask

  // Send the built stream with random overhead, idles and envelope starts.
  task automatic send(input string req, input bit noisy);
    int gap = 0;
    bit first = 1;
    while (byte_q.size() > 0) begin
      if (noisy && ($urandom() % 8) == 0) cyc($urandom(), 1, 1, $urandom() % 2, "R3");
      else if (noisy && ($urandom() % 8) == 0) cyc($urandom(), 0, $urandom() % 2, $urandom() % 2, "R8");
      else begin
        bit s = first || (noisy && gap >= 20 && ($urandom() % 40) == 0);
        cyc(byte_q.pop_front(), 1, 0, s, req);
        gap = s ? 0 : gap + 1;
        first = 0;
      end
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int w0;
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();

    // R2: payload bytes before first start are dropped
    for (int i = 0; i < 40; i++) cyc(8'hFF, 1, 0, 0, "R2");
    chk(words_seen == 0, "R2", words_seen, 0);
    for (int i = 0; i < 3; i++) cyc(8'h00, 1, 1, 0, "R3");
    for (int i = 0; i < 3; i++) cyc(8'h77, 0, 0, 1, "R8");

    // R4: directed MSB-first pattern
    build(4, 1);
    w0 = words_seen;
    send("R4", 0);
    chk(words_seen - w0 == 4, "R6", words_seen - w0, 4);
    chk(cnt_m == 0, "R6", cnt_m, 0);

    // R7: continuation across start pulse mid-word, back-to-back streams
    build(4, 1);
    cyc(byte_q.pop_front(), 1, 0, 0, "R7");
    cyc(byte_q.pop_front(), 1, 0, 1, "R7");
    send("R7", 0);

    // Reset mid-word clears leftover
    build(4, 0);
    for (int i = 0; i < 10; i++) cyc(byte_q.pop_front(), 1, 0, i == 0, "R1");
    do_reset();

    // Random rounds with overhead, idles and moving envelope starts
    for (int r = 0; r < 12; r++) begin
      int n = 4 * (1 + $urandom() % 6);
      build(n, 0);
      w0 = words_seen;
      send("R7", 1);
      for (int i = 0; i < 3; i++) cyc($urandom(), 0, 0, 0, "R8");
      chk(words_seen - w0 == n, "R6", words_seen - w0, n);
    end
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule